// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block keeps the 12-bit fetch address of a small 4-bit controller and computes the address of the next instruction once per instruction cycle. A decoder outside the block presents an operation code, an 11-bit target field and an instruction-length flag. The datapath presents the 4-bit accumulator, the carry flag and the 4-bit memory nibble at the data pointer. From these the block chooses one next address:

- a plain advance;
- a direct jump;
- a conditional branch;
- a subroutine call or return;
- a computed jump.

Bit 11 of the fetch address selects one of two ROM banks. Only the bank-select operation, a return or a computed jump changes that bit. Jumps, branches, calls and advances keep it.

The block also holds a 3-bit page register used by the computed jump, and a small circular return-address stack. Its depth is set by a parameter. When the stack overflows or underflows, a sticky error flag is raised. Every register updates on a rising clock edge while `cyc_en` is high.

Top module: `pcu_top`

## Requirements
- R1: A synchronous reset (`rst` high) clears the fetch address, the page register, the bank bit, the stack (so `stk_empty` reads 1) and `stk_err`.
- R2: While `cyc_en` is low, no state changes: `pc`, the page register, the stack and `stk_err` keep their values.
- R3: Operation code 0 (advance) adds 1 to `pc[10:0]` when `two_word` is 0, or 2 when it is 1. The sum wraps within bits 10..0, and `pc[11]` is kept.
- R4: Operation code 1 (jump) loads `pc[10:0]` from `tgt` and keeps `pc[11]`.
- R5: Operation code 2 (branch) loads `pc[10:0]` from `tgt` when the condition selected by `cond_sel` holds, and keeps `pc[11]`. The conditions are:
  - codes 0..3: accumulator bit 0..3 is 1;
  - code 4: accumulator equals 0;
  - code 5: accumulator is not 0;
  - code 6: carry is 0;
  - code 7: carry is 1.
- R6: A branch whose condition fails adds 2 to `pc[10:0]` (wrapping within bits 10..0) and keeps `pc[11]`.
- R7: Operation code 3 (call) pushes the 12-bit value {`pc[11]`, `pc[10:0]`+2 wrapped} and loads `pc[10:0]` from `tgt`, keeping `pc[11]`.
- R8: Operation code 4 (return) pops the most recent pushed value into all 12 bits of `pc`, in last-in first-out order, and restores the bank bit.
- R9: Operation code 5 (page load) stores `mem_nib[2:0]` in the page register (bit 3 is dropped) and advances `pc` as in R3.
- R10: Operation code 6 (computed jump) sets `pc` to {0, page, `acc`, `mem_nib`}, so bit 11 becomes 0.
- R11: Operation code 7 (bank select) sets `pc[11]` to `tgt[0]` and advances `pc[10:0]` as in R3.
- R12: A push when the stack already holds DEPTH entries (default 4) overwrites the oldest entry and sets `stk_err`. `stk_err` stays set until reset.
- R13: A pop from an empty stack loads `pc` with 0 and sets `stk_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_en | input | 1 | Instruction-cycle enable |
| op_code | input | 3 | Pre-decoded operation (encodings in R3..R11) |
| cond_sel | input | 3 | Branch condition select (encodings in R5) |
| tgt | input | 11 | Target field; bit 0 is the bank value for bank select |
| acc | input | 4 | Accumulator |
| carry | input | 1 | Carry flag |
| mem_nib | input | 4 | Memory nibble at the data pointer |
| two_word | input | 1 | Current instruction occupies two words |
| pc | output | 12 | Fetch address; bit 11 is the bank |
| stk_empty | output | 1 | Return stack holds no entries |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The assertions assume that reset is applied before the first enabled cycle. They also assume that `op_code` and the operand inputs stay constant between the clock edges around which they are sampled. The bench meets both conditions: it starts every scenario from reset or from a known state, and it changes inputs only on the falling edge, one operation per enabled cycle. All eight operation codes are legal, so the stimulus never needs an illegal-code guard. The bench avoids relying on stack contents left over from earlier scenarios by resetting before each stack test.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam int unsigned PC_W  = 12;
  localparam int unsigned LOW_W = 11;

  typedef enum logic [2:0] {
    OP_SEQ  = 3'd0,
    OP_JMP  = 3'd1,
    OP_BR   = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_PAGE = 3'd5,
    OP_CJMP = 3'd6,
    OP_BANK = 3'd7
  } pcu_op_e;

  typedef enum logic [2:0] {
    CND_A0  = 3'd0,
    CND_A1  = 3'd1,
    CND_A2  = 3'd2,
    CND_A3  = 3'd3,
    CND_AZ  = 3'd4,
    CND_ANZ = 3'd5,
    CND_CLR = 3'd6,
    CND_CST = 3'd7
  } pcu_cond_e;

  // Advance the low 11 bits by inc, keeping the bank bit.
  function automatic logic [PC_W-1:0] pc_adv(input logic [PC_W-1:0] p,
                                             input logic [1:0] inc);
    logic [LOW_W-1:0] low;
    low = p[LOW_W-1:0] + LOW_W'(inc);
    return {p[PC_W-1], low};
  endfunction

  // Replace the low 11 bits, keeping the bank bit.
  function automatic logic [PC_W-1:0] pc_load(input logic [PC_W-1:0] p,
                                              input logic [LOW_W-1:0] t);
    return {p[PC_W-1], t};
  endfunction

  function automatic logic [1:0] len_inc(input logic two);
    return two ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/pcu_cond.sv
module pcu_cond
  import pcu_pkg::*;
(
  input  logic [2:0] cond_sel,
  input  logic [3:0] acc,
  input  logic       carry,
  output logic       taken
);

  logic acc_zero;
  assign acc_zero = (acc == 4'd0);

  always_comb begin
    unique case (pcu_cond_e'(cond_sel))
      CND_A0:  taken = acc[0];
      CND_A1:  taken = acc[1];
      CND_A2:  taken = acc[2];
      CND_A3:  taken = acc[3];
      CND_AZ:  taken = acc_zero;
      CND_ANZ: taken = !acc_zero;
      CND_CLR: taken = !carry;
      CND_CST: taken = carry;
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcu_stack.sv
module pcu_stack
  import pcu_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            push,
  input  logic            pop,
  input  logic [PC_W-1:0] din,
  output logic [PC_W-1:0] dout,
  output logic            empty,
  output logic            err
);

  localparam int unsigned SPW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW  = $clog2(DEPTH + 1);
  localparam logic [SPW-1:0] SP_LAST = SPW'(DEPTH - 1);
  localparam logic [CW-1:0]  CNT_MAX = CW'(DEPTH);

  logic [PC_W-1:0] mem [DEPTH];
  logic [SPW-1:0]  sp_q;
  logic [CW-1:0]   cnt_q;
  logic            err_q;
  logic [SPW-1:0]  sp_inc, sp_dec;
  logic            full;

  // Named events for the checks
  logic push_ev, pop_ev, ovf_ev, unf_ev;

  assign full    = (cnt_q == CNT_MAX);
  assign empty   = (cnt_q == '0);
  assign sp_inc  = (sp_q == SP_LAST) ? '0 : sp_q + 1'b1;
  assign sp_dec  = (sp_q == '0) ? SP_LAST : sp_q - 1'b1;
  assign push_ev = en && push;
  assign pop_ev  = en && pop;
  assign ovf_ev  = push_ev && full;
  assign unf_ev  = pop_ev && empty;
  assign dout    = empty ? '0 : mem[sp_dec];
  assign err     = err_q;

  always_ff @(posedge clk) begin
    if (push_ev) mem[sp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (push_ev) begin
        sp_q <= sp_inc;
        if (!full) cnt_q <= cnt_q + 1'b1;
      end else if (pop_ev && !empty) begin
        sp_q  <= sp_dec;
        cnt_q <= cnt_q - 1'b1;
      end
      if (ovf_ev || unf_ev) err_q <= 1'b1;
    end
  end

  // R12
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_MAX);

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R12
  ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_ev |=> err && !empty);

  // R13
  unf_flag_chk: assert property (@(posedge clk) disable iff (rst)
    unf_ev |=> err && empty);

endmodule

// File: rtl/pcu_next.sv
module pcu_next
  import pcu_pkg::*;
(
  input  logic [2:0]       op_code,
  input  logic [PC_W-1:0]  pc_q,
  input  logic [LOW_W-1:0] tgt,
  input  logic [3:0]       acc,
  input  logic [3:0]       mem_nib,
  input  logic [2:0]       page_q,
  input  logic             taken,
  input  logic             two_word,
  input  logic [PC_W-1:0]  ret_addr,
  output logic [PC_W-1:0]  pc_d,
  output logic [PC_W-1:0]  link_addr
);

  logic [PC_W-1:0] seq_pc;

  assign seq_pc    = pc_adv(pc_q, len_inc(two_word));
  assign link_addr = pc_adv(pc_q, 2'd2);

  always_comb begin
    unique case (pcu_op_e'(op_code))
      OP_SEQ:  pc_d = seq_pc;
      OP_JMP:  pc_d = pc_load(pc_q, tgt);
      OP_BR:   pc_d = taken ? pc_load(pc_q, tgt) : pc_adv(pc_q, 2'd2);
      OP_CALL: pc_d = pc_load(pc_q, tgt);
      OP_RET:  pc_d = ret_addr;
      OP_PAGE: pc_d = seq_pc;
      OP_CJMP: pc_d = {1'b0, page_q, acc, mem_nib};
      OP_BANK: pc_d = {tgt[0], seq_pc[LOW_W-1:0]};
      default: pc_d = pc_q;
    endcase
  end

endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int unsigned STACK_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cyc_en,
  input  logic [2:0]  op_code,
  input  logic [2:0]  cond_sel,
  input  logic [10:0] tgt,
  input  logic [3:0]  acc,
  input  logic        carry,
  input  logic [3:0]  mem_nib,
  input  logic        two_word,
  output logic [11:0] pc,
  output logic        stk_empty,
  output logic        stk_err
);

  logic [PC_W-1:0] pc_q, pc_d, ret_addr, link_addr;
  logic [2:0]      page_q;
  logic            taken;
  logic            do_push, do_pop, page_ld;

  assign do_push = (op_code == OP_CALL);
  assign do_pop  = (op_code == OP_RET);
  assign page_ld = cyc_en && (op_code == OP_PAGE);

  pcu_cond u_cond (
    .cond_sel (cond_sel),
    .acc      (acc),
    .carry    (carry),
    .taken    (taken)
  );

  pcu_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .en    (cyc_en),
    .push  (do_push),
    .pop   (do_pop),
    .din   (link_addr),
    .dout  (ret_addr),
    .empty (stk_empty),
    .err   (stk_err)
  );

  pcu_next u_next (
    .op_code   (op_code),
    .pc_q      (pc_q),
    .tgt       (tgt),
    .acc       (acc),
    .mem_nib   (mem_nib),
    .page_q    (page_q),
    .taken     (taken),
    .two_word  (two_word),
    .ret_addr  (ret_addr),
    .pc_d      (pc_d),
    .link_addr (link_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      page_q <= '0;
    end else if (cyc_en) begin
      pc_q <= pc_d;
      if (page_ld) page_q <= mem_nib[2:0];
    end
  end

  assign pc = pc_q;

  // R2
  hold_pc_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_en |=> $stable(pc) && $stable(page_q));

  // R4
  jump_keep_bank_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_en && op_code == OP_JMP |=> pc[10:0] == $past(tgt) && pc[11] == $past(pc[11]));

  // R10
  cjmp_bank_clr_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_en && op_code == OP_CJMP |=> !pc[11] && pc[3:0] == $past(mem_nib));

  // R11
  bank_sel_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_en && op_code == OP_BANK |=> pc[11] == $past(tgt[0]));

  // R3
  seq_keep_bank_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_en && op_code == OP_SEQ |=> pc[11] == $past(pc[11]));

endmodule

// File: tb/sim_pcu_top.sv
module sim_pcu_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_en = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [2:0]  cond_sel = 3'd0;
  logic [10:0] tgt = '0;
  logic [3:0]  acc = '0;
  logic        carry = 1'b0;
  logic [3:0]  mem_nib = '0;
  logic        two_word = 1'b0;
  logic [11:0] pc;
  logic        stk_empty, stk_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcu_top u0 (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .op_code(op_code),
    .cond_sel(cond_sel), .tgt(tgt), .acc(acc), .carry(carry),
    .mem_nib(mem_nib), .two_word(two_word), .pc(pc),
    .stk_empty(stk_empty), .stk_err(stk_err)
  );

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One enabled operation; inputs change at negedge, result read at next negedge.
  task automatic step(input logic [2:0] op, input logic [10:0] t,
                      input logic two = 1'b0, input logic [2:0] cs = 3'd0,
                      input logic [3:0] a = 4'd0, input logic c = 1'b0,
                      input logic [3:0] m = 4'd0);
    op_code = op; tgt = t; two_word = two; cond_sel = cs;
    acc = a; carry = c; mem_nib = m; cyc_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cyc_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc_en = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pc", pc, 12'h000);
    chk("R1 empty", {11'd0, stk_empty}, 12'd1);
    chk("R1 err", {11'd0, stk_err}, 12'd0);
  endtask

  task automatic t_seq();
    step(3'd0, 11'd0, 1'b0);
    chk("R3 +1", pc, 12'h001);
    step(3'd0, 11'd0, 1'b1);
    chk("R3 +2", pc, 12'h003);
    op_code = 3'd1; tgt = 11'h555; cyc_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R2 hold", pc, 12'h003);
  endtask

  task automatic t_jump_bank();
    step(3'd7, 11'd1, 1'b1);
    chk("R11 bank1", pc, 12'h805);
    step(3'd1, 11'h7FE);
    chk("R4 jump keeps bank", pc, 12'hFFE);
    step(3'd0, 11'd0, 1'b1);
    chk("R3 wrap", pc, 12'h800);
    step(3'd7, 11'd0, 1'b0);
    chk("R11 bank0", pc, 12'h001);
  endtask

  task automatic t_branch();
    for (int i = 0; i < 8; i++) begin
      logic [3:0] a_t, a_n;
      logic c_t, c_n;
      a_t = 4'd0; a_n = 4'd0; c_t = 1'b0; c_n = 1'b0;
      if (i < 4) begin
        a_t = 4'(1 << i); a_n = ~a_t;
      end else if (i == 4) begin
        a_t = 4'd0; a_n = 4'd5;
      end else if (i == 5) begin
        a_t = 4'd9; a_n = 4'd0;
      end else if (i == 6) begin
        c_t = 1'b0; c_n = 1'b1;
      end else begin
        c_t = 1'b1; c_n = 1'b0;
      end
      step(3'd1, 11'h100);
      step(3'd2, 11'h2AA, 1'b1, 3'(i), a_t, c_t);
      chk($sformatf("R5 taken cond %0d", i), pc, 12'h2AA);
      step(3'd1, 11'h100);
      step(3'd2, 11'h2AA, 1'b1, 3'(i), a_n, c_n);
      chk($sformatf("R6 not taken cond %0d", i), pc, 12'h102);
    end
    step(3'd1, 11'h7FF);
    step(3'd2, 11'h123, 1'b1, 3'd7, 4'd0, 1'b0);
    chk("R6 wrap", pc, 12'h001);
  endtask

  task automatic t_page_cjmp();
    step(3'd1, 11'h050);
    step(3'd7, 11'd1, 1'b1);
    chk("R11 bank set", pc, 12'h852);
    step(3'd5, 11'd0, 1'b0, 3'd0, 4'd0, 1'b0, 4'hD);
    chk("R9 page advance", pc, 12'h853);
    step(3'd6, 11'd0, 1'b0, 3'd0, 4'hA, 1'b0, 4'h3);
    chk("R10 cjmp", pc, 12'h5A3);
  endtask

  task automatic t_call_ret();
    do_reset();
    step(3'd1, 11'h123);
    step(3'd7, 11'd1, 1'b1);
    chk("R11 pre-call", pc, 12'h925);
    step(3'd3, 11'h400);
    chk("R7 call", pc, 12'hC00);
    step(3'd7, 11'd0, 1'b1);
    step(3'd3, 11'h7FF);
    chk("R7 call2", pc, 12'h7FF);
    step(3'd4, 11'd0);
    chk("R8 ret1", pc, 12'h404);
    step(3'd4, 11'd0);
    chk("R8 ret2 bank", pc, 12'h927);
    chk("R8 empty", {11'd0, stk_empty}, 12'd1);
    chk("R8 no err", {11'd0, stk_err}, 12'd0);
  endtask

  task automatic t_overflow();
    do_reset();
    step(3'd1, 11'h010);
    for (int k = 1; k <= 5; k++) begin
      step(3'd3, 11'(k * 256));
      if (k == 4) chk("R12 no err at full", {11'd0, stk_err}, 12'd0);
    end
    chk("R12 err", {11'd0, stk_err}, 12'd1);
    for (int k = 4; k >= 1; k--) begin
      step(3'd4, 11'd0);
      chk($sformatf("R12 pop %0d", k), pc, 12'(k * 256 + 2));
    end
    chk("R12 empty", {11'd0, stk_empty}, 12'd1);
    chk("R12 sticky", {11'd0, stk_err}, 12'd1);
  endtask

  task automatic t_underflow();
    do_reset();
    step(3'd1, 11'h333);
    step(3'd4, 11'd0);
    chk("R13 pc zero", pc, 12'h000);
    chk("R13 err", {11'd0, stk_err}, 12'd1);
    do_reset();
    chk("R1 err cleared", {11'd0, stk_err}, 12'd0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_seq();
    t_jump_bank();
    t_branch();
    t_page_cjmp();
    t_call_ret();
    t_overflow();
    t_underflow();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule